// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel RGB panel that takes one pixel per clock. Both axes step through the same five intervals in a fixed order: a short lead-in before the sync pulse, the sync pulse, the back porch, the visible region and the front porch. After the front porch the axis returns to the lead-in. The horizontal axis counts pixel clocks. The vertical axis counts completed lines. From the two axis positions the block derives sync pulses, a data-enable, the coordinate of the visible pixel, and strobes that mark the start of each line and each frame.

Each interval is programmed with one 32-bit word that holds both axes. The horizontal value sits in the low half and the vertical value in the high half. Words go first into a shadow set. The whole shadow set, including the sync polarity bits, is copied into the working set at the moment one frame ends and the next begins, so a frame never runs with mixed parameters. The lead-in interval is usually set to one. In that case the front porch is set one smaller, so the line and frame lengths stay the same.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal axis visits lead-in, sync, back porch, active and front porch in that order, each for its programmed number of pixel clocks, and then wraps to lead-in. hsync is at its asserted level exactly during the sync interval.
- R2: The vertical axis advances by one at the end of each line and steps through the same five intervals counted in lines. vsync is at its asserted level for whole lines of the vertical sync interval. A frame lasts (sum of vertical intervals) times (sum of horizontal intervals) clocks.
- R3: Configuration writes happen on a clock edge with cfg_we high. cfg_addr selects the word: 0 lead-in, 1 sync, 2 back porch, 3 active size, 4 front porch, 5 polarity. In words 0 to 4, bits [15:0] hold the horizontal value and bits [31:16] hold the vertical value.
- R4: Word 3 carries the active width in bits [15:0] and the active height in bits [31:16].
- R5: de is high only when both axes are in their active interval. It is active-high.
- R6: pix_x is the offset inside the horizontal active interval (0 to width-1) and is 0 outside it. pix_y is the offset inside the vertical active interval (0 to height-1) and is 0 outside it. pix_y changes only on the first pixel of a line.
- R7: With polarity word bit 0 clear, hsync is active-high. Setting bit 0 inverts hsync. Bit 1 does the same for vsync. After reset both bits are clear.
- R8: Words written during a frame have no effect on that frame. They apply from the first pixel of the next frame.
- R9: An interval programmed as zero lasts one clock on the horizontal axis, or one line on the vertical axis.
- R10: line_start is high for exactly the first pixel of every line. frame_start is high for exactly the first pixel of the frame, which is the first pixel of the vertical lead-in.
- R11: While rst is high, every output is 0 and both the shadow and working sets return to the parameter defaults. The first clock edge after rst falls presents the first pixel of a frame using the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration word value |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | Data enable, high on visible pixels |
| pix_x | output | CW | Horizontal coordinate inside the active region |
| pix_y | output | CW | Vertical coordinate inside the active region |
| frame_start | output | 1 | One-clock strobe on the first pixel of a frame |
| line_start | output | 1 | One-clock strobe on the first pixel of a line |

## Verification
The bench builds the block with CW = 16 and small default timing words: a 16-pixel line and an 8-line frame of 128 clocks. With frames this short, every pixel of every frame can be compared against a model in the bench. Four more timing sets are loaded while a frame is running. They cover inverted sync polarity, a 220-clock frame, intervals programmed as zero, and a lead-in of two, so the shadow swap is exercised at every frame boundary. A reset in the middle of the run, issued while a different set is pending in the shadow, shows that reset restores the defaults.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Interval order along either axis; the sequence itself is behaviour.
  typedef enum logic [2:0] {
    PH_REF   = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  localparam int          NPH      = 5;     // intervals per axis
  localparam int          HALF     = 16;    // bit offset of the vertical field
  localparam logic [2:0]  ADDR_POL = 3'd5;  // polarity word select

endpackage

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
  import dtg_pkg::*;
#(
  parameter int          CW        = 16,
  parameter logic [31:0] RST_REF   = 32'h0001_0001,
  parameter logic [31:0] RST_SYNC  = 32'h0001_0002,
  parameter logic [31:0] RST_BACK  = 32'h0001_0003,
  parameter logic [31:0] RST_ACT   = 32'h0004_0008,
  parameter logic [31:0] RST_FRONT = 32'h0001_0002,
  parameter logic [1:0]  RST_POL   = 2'b00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [2:0]              addr,
  input  logic [31:0]             wdata,
  input  logic                    swap,
  output logic [NPH-1:0][CW-1:0]  h_len,
  output logic [NPH-1:0][CW-1:0]  v_len,
  output logic [1:0]              pol_nxt
);

  localparam logic [NPH-1:0][31:0] RST_SET =
    {RST_FRONT, RST_ACT, RST_BACK, RST_SYNC, RST_REF};

  logic [NPH-1:0][31:0] shd_q, wrk_q;
  logic [1:0]           pol_shd_q, pol_wrk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q     <= RST_SET;
      wrk_q     <= RST_SET;
      pol_shd_q <= RST_POL;
      pol_wrk_q <= RST_POL;
    end else begin
      // Swap takes the shadow as it stood before this edge's write.
      if (swap) begin
        wrk_q     <= shd_q;
        pol_wrk_q <= pol_shd_q;
      end
      if (we) begin
        if (addr == ADDR_POL)
          pol_shd_q <= wdata[1:0];
        else if (int'(addr) < NPH)
          shd_q[addr] <= wdata;
      end
    end
  end

  // Split every packed word into its horizontal and vertical lengths.
  for (genvar g = 0; g < NPH; g++) begin : g_split
    assign h_len[g] = wrk_q[g][CW-1:0];
    assign v_len[g] = wrk_q[g][HALF+CW-1:HALF];
  end

  // Polarity that the next pixel will use (new set at a frame boundary).
  assign pol_nxt = swap ? pol_shd_q : pol_wrk_q;

endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  input  logic [NPH-1:0][CW-1:0] len,
  output phase_e                 nxt_ph,
  output logic [CW-1:0]          nxt_cnt,
  output logic                   wrap
);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_len, eff_len;
  logic          at_last;

  always_comb begin
    cur_len = len[ph_q];
    // A zero length still occupies one step so the axis keeps moving.
    eff_len = (cur_len == '0) ? CW'(1) : cur_len;
    at_last = (cnt_q >= eff_len - CW'(1));
    nxt_ph  = ph_q;
    nxt_cnt = cnt_q;
    if (step) begin
      if (at_last) begin
        nxt_cnt = '0;
        nxt_ph  = (ph_q == PH_FRONT) ? PH_REF : phase_e'(ph_q + 3'd1);
      end else begin
        nxt_cnt = cnt_q + CW'(1);
      end
    end
  end

  assign wrap = step && at_last && (ph_q == PH_FRONT);

  // Reset parks the axis on its final step, so the first clock opens a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_FRONT;
      cnt_q <= '1;
    end else begin
      ph_q  <= nxt_ph;
      cnt_q <= nxt_cnt;
    end
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int          CW        = 16,
  parameter logic [31:0] RST_REF   = 32'h0001_0001,
  parameter logic [31:0] RST_SYNC  = 32'h0001_0002,
  parameter logic [31:0] RST_BACK  = 32'h0001_0003,
  parameter logic [31:0] RST_ACT   = 32'h0004_0008,
  parameter logic [31:0] RST_FRONT = 32'h0001_0002,
  parameter logic [1:0]  RST_POL   = 2'b00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          frame_start,
  output logic          line_start
);

  logic [NPH-1:0][CW-1:0] h_len, v_len;
  logic [1:0]             pol_nxt;
  phase_e                 h_nph, v_nph;
  logic [CW-1:0]          h_ncnt, v_ncnt;
  logic                   h_wrap, v_wrap;
  logic                   ls_nxt;

  dtg_cfg_regs #(
    .CW(CW), .RST_REF(RST_REF), .RST_SYNC(RST_SYNC), .RST_BACK(RST_BACK),
    .RST_ACT(RST_ACT), .RST_FRONT(RST_FRONT), .RST_POL(RST_POL)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .swap(v_wrap), .h_len(h_len), .v_len(v_len), .pol_nxt(pol_nxt)
  );

  dtg_axis #(.CW(CW)) u_hax (
    .clk(clk), .rst(rst), .step(1'b1), .len(h_len),
    .nxt_ph(h_nph), .nxt_cnt(h_ncnt), .wrap(h_wrap)
  );

  dtg_axis #(.CW(CW)) u_vax (
    .clk(clk), .rst(rst), .step(h_wrap), .len(v_len),
    .nxt_ph(v_nph), .nxt_cnt(v_ncnt), .wrap(v_wrap)
  );

  assign ls_nxt = (h_nph == PH_REF) && (h_ncnt == '0);

  // Outputs decoded from the next axis state and registered, so they line
  // up with the axis registers with no extra latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      de          <= 1'b0;
      pix_x       <= '0;
      pix_y       <= '0;
      frame_start <= 1'b0;
      line_start  <= 1'b0;
    end else begin
      hsync       <= (h_nph == PH_SYNC) ^ pol_nxt[0];
      vsync       <= (v_nph == PH_SYNC) ^ pol_nxt[1];
      de          <= (h_nph == PH_ACT) && (v_nph == PH_ACT);
      pix_x       <= (h_nph == PH_ACT) ? h_ncnt : '0;
      pix_y       <= (v_nph == PH_ACT) ? v_ncnt : '0;
      line_start  <= ls_nxt;
      frame_start <= ls_nxt && (v_nph == PH_REF) && (v_ncnt == '0);
    end
  end

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] pix_y,
  input logic          frame_start,
  input logic          line_start
);

  p_fs_on_ls_r10: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);

  p_fs_single_r10: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  p_ls_blank_r5: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (!de && pix_x == '0));

  p_x_step_r6: assert property (@(posedge clk) disable iff (rst)
    de |=> (!de || pix_x == $past(pix_x) + CW'(1)));

  p_y_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !line_start |-> $stable(pix_y));

  p_rst_quiet_r11: assert property (@(posedge clk)
    rst |=> (!de && !hsync && !vsync && !frame_start && !line_start));

endmodule

bind disp_timing_gen dtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
  .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start),
  .line_start(line_start)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;

  localparam int CW = 16;
  localparam int NV = 5;

  // Per row: words 0..5 as written at cfg_addr 0..5, then frame length.
  localparam logic [31:0] TBL [NV][7] = '{
    '{32'h0001_0001, 32'h0001_0002, 32'h0001_0003, 32'h0004_0008,
      32'h0001_0002, 32'h0000_0000, 32'd128},
    '{32'h0001_0001, 32'h0001_0002, 32'h0001_0003, 32'h0004_0008,
      32'h0001_0002, 32'h0000_0003, 32'd128},
    '{32'h0001_0001, 32'h0002_0003, 32'h0002_0002, 32'h0005_000A,
      32'h0001_0004, 32'h0000_0000, 32'd220},
    '{32'h0000_0000, 32'h0001_0000, 32'h0000_0001, 32'h0003_0006,
      32'h0000_0000, 32'h0000_0001, 32'd70},
    '{32'h0002_0002, 32'h0001_0001, 32'h0001_0001, 32'h0002_0004,
      32'h0002_0003, 32'h0000_0002, 32'd88}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          hsync, vsync, de, frame_start, line_start;
  logic [CW-1:0] pix_x, pix_y;

  int checks = 0;
  int fails  = 0;
  int mism [5];
  int fact [5];
  int fexp [5];

  always #2 clk = ~clk;

  disp_timing_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start),
    .line_start(line_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic note(input int g, input int a, input int e);
    if (a != e) begin
      if (mism[g] == 0) begin
        fact[g] = a;
        fexp[g] = e;
      end
      mism[g]++;
    end
  endtask

  function automatic void locate(input int lens[5], input int pos,
                                 output int ph, output int off);
    int acc = 0;
    ph = 4;
    off = 0;
    for (int k = 0; k < 5; k++) begin
      if (pos >= acc && pos < acc + lens[k]) begin
        ph = k;
        off = pos - acc;
      end
      acc += lens[k];
    end
  endfunction

  task automatic check_reset_quiet(input string tag);
    chk({hsync, vsync, de, frame_start, line_start} == 5'b0 &&
        pix_x == '0 && pix_y == '0, tag,
        int'({hsync, vsync, de, frame_start, line_start}), 0);
  endtask

  // Called at the sampling point of pixel 0 of a frame running set cur.
  // Writes set nx (if nx >= 0) during the first six pixels of that frame.
  task automatic verify_frame(input int cur, input int nx);
    int hl [5];
    int vl [5];
    int llen = 0;
    int flen;
    logic [1:0] pol;
    bit all_ok;
    for (int k = 0; k < 5; k++) begin
      hl[k] = (TBL[cur][k][15:0] == 16'd0) ? 1 : int'(TBL[cur][k][15:0]);
      vl[k] = (TBL[cur][k][31:16] == 16'd0) ? 1 : int'(TBL[cur][k][31:16]);
      llen += hl[k];
      mism[k] = 0;
    end
    flen = int'(TBL[cur][6]);
    pol  = TBL[cur][5][1:0];
    for (int p = 0; p < flen; p++) begin
      int hp, ho, vp, vo, lp, ln;
      lp = p % llen;
      ln = p / llen;
      locate(hl, lp, hp, ho);
      locate(vl, ln, vp, vo);
      note(0, int'(hsync), int'((hp == 1) ^ pol[0]));
      note(1, int'(vsync), int'((vp == 1) ^ pol[1]));
      note(2, int'(de), int'(hp == 3 && vp == 3));
      note(3, int'({pix_x, pix_y}),
           ((hp == 3 ? ho : 0) << 16) | (vp == 3 ? vo : 0));
      note(4, int'({frame_start, line_start}),
           ((lp == 0 && ln == 0) ? 2 : 0) | (lp == 0 ? 1 : 0));
      if (nx >= 0 && p < 6) begin
        cfg_we    = 1'b1;
        cfg_addr  = 3'(p);
        cfg_wdata = TBL[nx][p];
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk(mism[0] == 0, $sformatf("R1 hsync set %0d", cur), fact[0], fexp[0]);
    chk(mism[1] == 0, $sformatf("R2 vsync set %0d", cur), fact[1], fexp[1]);
    chk(mism[2] == 0, $sformatf("R5 de set %0d", cur), fact[2], fexp[2]);
    chk(mism[3] == 0, $sformatf("R6 x/y set %0d", cur), fact[3], fexp[3]);
    chk(mism[4] == 0, $sformatf("R10 strobes set %0d", cur), fact[4], fexp[4]);
    chk(frame_start == 1'b1, $sformatf("R2 frame length set %0d", cur),
        int'(frame_start), 1);
    all_ok = (mism[0] + mism[1] + mism[2] + mism[3] + mism[4]) == 0;
    case (cur)
      1: chk(all_ok, "R7 inverted hsync and vsync", int'(all_ok), 1);
      2: chk(all_ok, "R3 R4 packed halves decoded", int'(all_ok), 1);
      3: chk(all_ok, "R9 zero intervals last one step", int'(all_ok), 1);
      4: chk(all_ok, "R3 lead-in of two", int'(all_ok), 1);
      default: ;
    endcase
    if (nx >= 0)
      chk(all_ok, "R8 writes held until next frame", int'(all_ok), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_quiet("R11 outputs low in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(frame_start && line_start, "R11 first pixel after reset",
        int'({frame_start, line_start}), 3);

    // Vector walk: each frame is checked against its set while the next
    // set is loaded into the shadow.
    for (int i = 0; i < NV; i++)
      verify_frame(i, (i < NV - 1) ? i + 1 : 2);

    // Reset while set 2 is pending must bring back the defaults.
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_quiet("R11 outputs low in mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    verify_frame(0, -1);
    chk(mism[0] + mism[1] + mism[2] + mism[3] + mism[4] == 0,
        "R11 defaults restored after reset",
        mism[0] + mism[1] + mism[2] + mism[3] + mism[4], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule